// File: doc/BRIEF.md
# Flash Write-Protection Status Register

This block holds the write-protection state that sits beside a serial flash command decoder. It keeps two region-select bits, a lock bit and the write-enable latch. It takes decoded, single-cycle command strobes from the serial front end: set write enable, arm a status write, status write with its data byte, and "some other instruction finished". It also takes a live write-protect pin, which is active low.

When the decoder has a program or erase ready, it raises a request with the operation type and target address. One cycle later the block answers with a result strobe and a grant or deny decision. The decision uses the write-enable latch and the protected region selected by the region bits. A whole-array erase is refused whenever any region is protected.

Status writes are a two-step sequence. The arming command must be the instruction immediately before the status write. While the lock bit is set and the pin is held low, the protection bits are frozen.

Top module: `flash_wprot`

## Requirements
- R1: After reset the region bits are 2'b11, the lock bit is 1, the write-enable latch is 0, and no status write is armed.
- R2: The region code on `stat_bp` selects the protected addresses in the 128 KB space. 2'b00 protects nothing. 2'b01 protects 0x18000 to 0x1FFFF. 2'b10 protects 0x10000 to 0x1FFFF. 2'b11 protects every address. A program (`req_op`=0), sector erase (1) or block erase (2) whose address is protected is denied.
- R3: A request in cycle N produces `res_valid` high, with `res_grant` holding the decision, in cycle N+1. There is no result without a request.
- R4: `cmd_wren` sets the write-enable latch. No request is granted while the latch is 0.
- R5: A whole-array erase (`req_op`=3) is denied whenever the region code is not 2'b00, whatever its address.
- R6: A denied request leaves the write-enable latch unchanged. A granted request clears it, unless `cmd_wren` arrives in the same cycle.
- R7: `cmd_wrsr` loads `wrsr_data[2]` into the lock bit and `wrsr_data[1:0]` into the region bits. It does so only when the instruction just before it was `cmd_ewsr`. Otherwise the register keeps its value.
- R8: Any instruction completing after `cmd_ewsr` cancels the armed status write. This covers `cmd_wren`, `cmd_other`, a request, or a status write itself.
- R9: While the lock bit is 1 and `wp_n` is 0, a status write is ignored but still consumes the arming. With `wp_n` high, the bits are writable even when the lock bit is 1.
- R10: When a request and a status write fall in the same cycle, the request is judged against the bits held before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Set-write-enable instruction completed |
| cmd_ewsr | input | 1 | Arm-status-write instruction completed |
| cmd_wrsr | input | 1 | Status-write instruction completed |
| wrsr_data | input | 3 | Status data: [2] lock bit, [1:0] region code |
| cmd_other | input | 1 | Any other instruction completed |
| req_valid | input | 1 | Program/erase request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 whole-array erase |
| req_addr | input | 17 | Target byte address |
| stat_bp | output | 2 | Region code |
| stat_bpl | output | 1 | Lock bit |
| stat_wel | output | 1 | Write-enable latch |
| res_valid | output | 1 | Decision strobe, one cycle after the request |
| res_grant | output | 1 | Decision: 1 grant, 0 deny |

## Verification
The protection check and a status-register write can land in one cycle. The bench provokes this by arming a status write, then presenting a request and the status write together. It does this once where the old region covers the address and the new one does not, and once the other way round. The scoreboard expects the decision computed from the pre-write bits. A following status readback confirms that the write itself was applied.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;
   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_SECT  = 2'd1,
      OP_BLOCK = 2'd2,
      OP_WHOLE = 2'd3
   } wp_op_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] region;
   } wp_bits_t;

   localparam wp_bits_t WP_RESET_BITS = '{lock: 1'b1, region: 2'b11};
endpackage

// File: rtl/fwp_region.sv
module fwp_region #(
   parameter int ADDR_W   = 17,
   parameter bit FROM_TOP = 1'b1
) (
   input  logic [1:0]        region,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              any
);
   localparam int MSB = ADDR_W - 1;

   logic [1:0] top2;
   logic       unused_low;

   assign top2       = addr[MSB -: 2];
   assign unused_low = ^addr[MSB-2:0];
   assign any        = |region;

   generate
      if (FROM_TOP) begin : g_top
         always_comb begin
            case (region)
               2'b01:   hit = (top2 == 2'b11);
               2'b10:   hit = top2[1];
               2'b11:   hit = 1'b1;
               default: hit = 1'b0;
            endcase
         end
      end else begin : g_bottom
         always_comb begin
            case (region)
               2'b01:   hit = (top2 == 2'b00);
               2'b10:   hit = ~top2[1];
               2'b11:   hit = 1'b1;
               default: hit = 1'b0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fwp_sreg.sv
module fwp_sreg
   import flash_wprot_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wp_n,
   input  logic     cmd_wren,
   input  logic     cmd_ewsr,
   input  logic     cmd_wrsr,
   input  wp_bits_t wr_bits,
   input  logic     cmd_other,
   input  logic     req_fire,
   input  logic     grant_now,
   output wp_bits_t bits_q,
   output logic     wel_q
);
   logic pend_q;
   logic frozen;
   logic wr_ok;
   logic any_instr;

   assign frozen    = bits_q.lock & ~wp_n;
   assign wr_ok     = cmd_wrsr & pend_q & ~frozen;
   assign any_instr = cmd_wren | cmd_wrsr | cmd_other | req_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= WP_RESET_BITS;
         wel_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_ok)
            bits_q <= wr_bits;
         if (cmd_wren)
            wel_q <= 1'b1;
         else if (grant_now)
            wel_q <= 1'b0;
         if (cmd_ewsr)
            pend_q <= 1'b1;
         else if (any_instr)
            pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/fwp_judge.sv
module fwp_judge
   import flash_wprot_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter bit FROM_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        region,
   input  logic              wel,
   output logic              grant_now,
   output logic              res_valid,
   output logic              res_grant
);
   logic   hit;
   logic   any;
   logic   permit;
   wp_op_e op;

   fwp_region #(.ADDR_W(ADDR_W), .FROM_TOP(FROM_TOP)) u_region (
      .region (region),
      .addr   (req_addr),
      .hit    (hit),
      .any    (any)
   );

   assign op        = wp_op_e'(req_op);
   assign permit    = wel & ((op == OP_WHOLE) ? ~any : ~hit);
   assign grant_now = req_valid & permit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_grant <= 1'b0;
      end else begin
         res_valid <= req_valid;
         res_grant <= grant_now;
      end
   end
endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
   import flash_wprot_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter bit FROM_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              cmd_wren,
   input  logic              cmd_ewsr,
   input  logic              cmd_wrsr,
   input  logic [2:0]        wrsr_data,
   input  logic              cmd_other,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [1:0]        stat_bp,
   output logic              stat_bpl,
   output logic              stat_wel,
   output logic              res_valid,
   output logic              res_grant
);
   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("flash_wprot: ADDR_W must be at least 3");
      end
   endgenerate

   wp_bits_t bits_q;
   logic     wel_q;
   logic     grant_now;

   fwp_sreg u_sreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wp_n      (wp_n),
      .cmd_wren  (cmd_wren),
      .cmd_ewsr  (cmd_ewsr),
      .cmd_wrsr  (cmd_wrsr),
      .wr_bits   (wp_bits_t'(wrsr_data)),
      .cmd_other (cmd_other),
      .req_fire  (req_valid),
      .grant_now (grant_now),
      .bits_q    (bits_q),
      .wel_q     (wel_q)
   );

   fwp_judge #(.ADDR_W(ADDR_W), .FROM_TOP(FROM_TOP)) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .region    (bits_q.region),
      .wel       (wel_q),
      .grant_now (grant_now),
      .res_valid (res_valid),
      .res_grant (res_grant)
   );

   assign stat_bp  = bits_q.region;
   assign stat_bpl = bits_q.lock;
   assign stat_wel = wel_q;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wp_n,
   input logic       cmd_wren,
   input logic       cmd_wrsr,
   input logic       req_valid,
   input logic [1:0] req_op,
   input logic [1:0] stat_bp,
   input logic       stat_bpl,
   input logic       stat_wel,
   input logic       res_valid,
   input logic       res_grant
);
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (stat_bp == 2'b11 && stat_bpl && !stat_wel && !res_valid));

   a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   a_r4_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !stat_wel) |=> !res_grant);

   a_r5_whole_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd3 && stat_bp != 2'b00) |=> !res_grant);

   a_r6_deny_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cmd_wren) |=> (res_grant || stat_wel == $past(stat_wel)));

   a_r6_grant_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cmd_wren) |=> (!res_grant || !stat_wel));

   a_r7_bits_need_wrsr: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wrsr |=> ($stable(stat_bp) && $stable(stat_bpl)));

   a_r9_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_bpl && !wp_n) |=> ($stable(stat_bp) && $stable(stat_bpl)));
endmodule

bind flash_wprot fwp_checker u_fwp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wp_n      (wp_n),
   .cmd_wren  (cmd_wren),
   .cmd_wrsr  (cmd_wrsr),
   .req_valid (req_valid),
   .req_op    (req_op),
   .stat_bp   (stat_bp),
   .stat_bpl  (stat_bpl),
   .stat_wel  (stat_wel),
   .res_valid (res_valid),
   .res_grant (res_grant)
);

// File: tb/sim_flash_wprot.sv
`timescale 1ns/1ps
module sim_flash_wprot;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_n = 1'b1;
   logic          cmd_wren = 1'b0, cmd_ewsr = 1'b0, cmd_wrsr = 1'b0, cmd_other = 1'b0;
   logic [2:0]    wrsr_data = 3'd0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    stat_bp;
   logic          stat_bpl, stat_wel, res_valid, res_grant;

   always #2.5 clk = ~clk;

   flash_wprot u0 (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
      .cmd_wren(cmd_wren), .cmd_ewsr(cmd_ewsr), .cmd_wrsr(cmd_wrsr),
      .wrsr_data(wrsr_data), .cmd_other(cmd_other),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .stat_bp(stat_bp), .stat_bpl(stat_bpl), .stat_wel(stat_wel),
      .res_valid(res_valid), .res_grant(res_grant)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   bit    exp_q[$];
   string tag_q[$];

   logic [1:0] m_bp  = 2'b11;
   logic       m_bpl = 1'b1;
   logic       m_wel = 1'b0;
   logic       m_pend = 1'b0;

   function automatic bit covered(input logic [1:0] b, input logic [AW-1:0] a);
      case (b)
         2'b01:   return a >= 17'h18000;
         2'b10:   return a >= 17'h10000;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(input bit wren, input bit ewsr, input bit wrsr, input logic [2:0] d,
                       input bit other, input bit rq, input logic [1:0] op,
                       input logic [AW-1:0] a, input string tag);
      bit permit;
      bit frozen;
      @(negedge clk);
      cmd_wren = wren; cmd_ewsr = ewsr; cmd_wrsr = wrsr; wrsr_data = d;
      cmd_other = other; req_valid = rq; req_op = op; req_addr = a;
      permit = m_wel && ((op == 2'd3) ? (m_bp == 2'b00) : !covered(m_bp, a));
      if (rq) begin
         exp_q.push_back(permit);
         tag_q.push_back(tag);
      end
      frozen = m_bpl && !wp_n;
      @(posedge clk);
      if (wrsr && m_pend && !frozen) {m_bpl, m_bp} = d;
      if (wren) m_wel = 1'b1;
      else if (rq && permit) m_wel = 1'b0;
      if (ewsr) m_pend = 1'b1;
      else if (wren || wrsr || other || rq) m_pend = 1'b0;
      #1;
      cmd_wren = 0; cmd_ewsr = 0; cmd_wrsr = 0; cmd_other = 0; req_valid = 0;
   endtask

   task automatic t_wren();                  step(1,0,0,3'd0,0,0,2'd0,'0,"R4"); endtask
   task automatic t_ewsr();                  step(0,1,0,3'd0,0,0,2'd0,'0,"R7"); endtask
   task automatic t_wrsr(input logic [2:0] d); step(0,0,1,d,0,0,2'd0,'0,"R7"); endtask
   task automatic t_other();                 step(0,0,0,3'd0,1,0,2'd0,'0,"R8"); endtask
   task automatic t_req(input logic [1:0] op, input logic [AW-1:0] a, input string tag);
      step(0,0,0,3'd0,0,1,op,a,tag);
   endtask

   task automatic chk_stat(input string tag);
      @(negedge clk);
      n_cmp++;
      if (stat_bp !== m_bp || stat_bpl !== m_bpl || stat_wel !== m_wel) begin
         n_bad++;
         $display("FAIL %s status: actual bp=%b bpl=%b wel=%b expected bp=%b bpl=%b wel=%b",
                  tag, stat_bp, stat_bpl, stat_wel, m_bp, m_bpl, m_wel);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R3 unexpected result: actual res_valid=1 expected res_valid=0");
         end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (res_grant !== e) begin
               n_bad++;
               $display("FAIL %s decision: actual grant=%b expected grant=%b", t, res_grant, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk_stat("R1");                      // reset state
      t_wrsr(3'b000); chk_stat("R1");      // no arming after reset
      t_req(2'd0, 17'h00000, "R4");        // latch clear -> deny
      t_wren(); chk_stat("R4");
      t_req(2'd0, 17'h00000, "R2");        // region 11 covers all -> deny
      chk_stat("R6");                      // latch kept after deny
      t_ewsr(); t_wrsr(3'b000); chk_stat("R9");  // wp_n high: lock bit writable
      t_req(2'd0, 17'h1FFFF, "R2");        // grant
      chk_stat("R6");                      // latch cleared
      t_req(2'd3, 17'h00000, "R4");        // whole erase, no latch
      t_wren(); t_req(2'd3, 17'h00000, "R5"); // nothing protected -> grant
      t_ewsr(); t_wrsr(3'b001); chk_stat("R7");
      t_wren(); t_req(2'd0, 17'h17FFF, "R2");
      t_wren(); t_req(2'd0, 17'h18000, "R2");
      t_req(2'd1, 17'h1FFFF, "R2");
      t_req(2'd2, 17'h10000, "R2");
      t_wren(); t_req(2'd3, 17'h00000, "R5");
      chk_stat("R6");
      t_ewsr(); t_wrsr(3'b010); chk_stat("R7");
      t_req(2'd2, 17'h0FFFF, "R2");
      t_wren(); t_req(2'd1, 17'h10000, "R2");
      t_ewsr(); t_wren(); t_wrsr(3'b000); chk_stat("R8");
      t_ewsr(); t_other(); t_wrsr(3'b000); chk_stat("R8");
      t_ewsr(); t_req(2'd0, 17'h00000, "R8"); t_wrsr(3'b000); chk_stat("R8");
      t_ewsr(); t_wrsr(3'b001); t_wrsr(3'b000); chk_stat("R8");
      t_ewsr(); t_wrsr(3'b110); chk_stat("R7");
      wp_n = 1'b0;
      t_ewsr(); t_wrsr(3'b000); chk_stat("R9");   // frozen
      t_wrsr(3'b000); chk_stat("R9");             // arming consumed
      wp_n = 1'b1;
      t_ewsr(); t_wrsr(3'b010); chk_stat("R9");   // writable again
      // R10: request and status write in the same cycle
      t_wren(); t_ewsr();
      step(0,0,1,3'b000,0,1,2'd0,17'h1FFFF,"R10"); // old region 10 covers -> deny
      chk_stat("R10");
      t_ewsr();
      step(0,0,1,3'b011,0,1,2'd0,17'h00000,"R10"); // old region 00 -> grant
      chk_stat("R10");
      t_wren(); step(1,0,0,3'd0,0,1,2'd0,17'h00000,"R6"); // covered; wren same cycle
      chk_stat("R6");
      repeat (3) @(negedge clk);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R3 pending results: actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end
endmodule